// File: doc/BRIEF.md
# Bit Count and Reverse Unit

This unit takes one integer operand and returns either a count of its leading bits or a rearranged copy of it. It has six operations. Two of them count: the leading-zero count, and the count of leading bits that equal the sign bit. Four of them move bits or bytes: mirror all bits, reverse all bytes, swap the two bytes inside every 16-bit lane, and reverse the bytes inside every 32-bit lane. A width input chooses between a full 64-bit operand and a narrow 32-bit operand. In narrow mode the unit reads only the low half of the operand.

Each operation has a latency of one cycle. When `in_valid` is high on a rising clock edge, the unit computes the result from that cycle's inputs and registers it. The new result appears after that edge, and `out_valid` is high for one cycle alongside it. While `in_valid` is low, the result register keeps its value. A count is returned as an unsigned number in the low bits of `result`, and all higher bits are zero.

Top module: `bcr_unit`

## Requirements
- R1: During reset and directly after it, `out_valid` is 0 and `result` is 0.
- R2: If `in_valid` is 1 at a rising edge, `out_valid` is 1 after that edge, and `result` holds the value computed from the inputs sampled at that edge.
- R3: If `in_valid` is 0 at a rising edge, `out_valid` is 0 after that edge and `result` keeps its value, whatever the other inputs do.
- R4: Op code 0 (leading zeros). The result is the number of zero bits above the highest set bit of the selected width. A zero operand gives 64 in wide mode and 32 in narrow mode.
- R5: Op code 1 (leading sign bits). The result is the number of bits directly below the top bit of the selected width that equal the top bit; the top bit itself is not counted. An operand that is all zeros or all ones gives 63 in wide mode and 31 in narrow mode.
- R6: Op code 2 (bit mirror). Bit i of the result equals operand bit W-1-i, where W is 64 or 32.
- R7: Op code 3 (full byte reverse). Byte k of the result equals operand byte W/8-1-k, for all 8 bytes in wide mode or the low 4 bytes in narrow mode.
- R8: Op code 4 (halfword byte swap). In each of the W/16 16-bit lanes, the two bytes change places.
- R9: Op code 5 (word byte reverse). In each of the W/32 32-bit lanes the byte order is reversed, so narrow mode has a single lane.
- R10: With `wide` = 0 (narrow mode), operand bits 63:32 have no effect and result bits 63:32 are zero.
- R11: Op codes 6 and 7 are reserved and give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Enables capture of a new result |
| op_sel | input | 3 | Operation code, 0 to 5, 6 and 7 reserved |
| wide | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| operand | input | 64 | Source operand |
| out_valid | output | 1 | A new result was captured on the previous edge |
| result | output | 64 | Registered result |

## Verification
The directed operands are chosen for the counts and the sign handling:
- Zero and all ones tell the empty-search cases apart from normal ones.
- A single set top bit, a lone low bit and alternating sign patterns check the width minus one and minus two offsets of the counts, and show whether the sign bit is wrongly included.
- Operands whose upper half is set and lower half distinct, applied in narrow mode, show whether the upper half leaks into the result or the wrong width is used.

The random operands are shifted right by a random distance and sometimes inverted, so leading runs of every length from 0 to 64 are tried for all six operations in both widths. Distinct byte values in each lane show whether the swizzles move the wrong lane or the wrong byte.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LZC   = 3'd0,
    OP_LSC   = 3'd1,
    OP_BMIR  = 3'd2,
    OP_BREV  = 3'd3,
    OP_HSWAP = 3'd4,
    OP_WREV  = 3'd5
  } bcr_op_e;
endpackage

// File: rtl/bcr_msb_find.sv
// Priority encoder: index of the highest set bit of vec.
module bcr_msb_find #(
  parameter int W     = 64,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             none_set
);
  always_comb begin
    idx      = '0;
    none_set = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        idx      = IDX_W'(i);
        none_set = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcr_swizzle.sv
// Bit and byte rearrangements. x_m has its upper half already cleared in
// narrow mode.
module bcr_swizzle #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] x_m,
  input  logic              wide,
  output logic [DATA_W-1:0] mir,
  output logic [DATA_W-1:0] brev,
  output logic [DATA_W-1:0] hswap,
  output logic [DATA_W-1:0] wrev
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NB     = DATA_W / 8;
  localparam int NB_H   = HALF_W / 8;
  localparam int N16    = DATA_W / 16;
  localparam int N32    = DATA_W / 32;

  logic [DATA_W-1:0] mir_full, mir_half, brev_full, brev_half;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mir_f
    assign mir_full[i] = x_m[DATA_W-1-i];
  end
  for (genvar i = 0; i < HALF_W; i++) begin : g_mir_h
    assign mir_half[i] = x_m[HALF_W-1-i];
  end
  assign mir_half[DATA_W-1:HALF_W] = '0;

  for (genvar b = 0; b < NB; b++) begin : g_brev_f
    assign brev_full[8*b +: 8] = x_m[8*(NB-1-b) +: 8];
  end
  for (genvar b = 0; b < NB_H; b++) begin : g_brev_h
    assign brev_half[8*b +: 8] = x_m[8*(NB_H-1-b) +: 8];
  end
  assign brev_half[DATA_W-1:HALF_W] = '0;

  for (genvar l = 0; l < N16; l++) begin : g_h16
    assign hswap[16*l +: 8]     = x_m[16*l+8 +: 8];
    assign hswap[16*l+8 +: 8]   = x_m[16*l +: 8];
  end

  for (genvar l = 0; l < N32; l++) begin : g_w32
    for (genvar b = 0; b < 4; b++) begin : g_b
      assign wrev[32*l+8*b +: 8] = x_m[32*l+8*(3-b) +: 8];
    end
  end

  assign mir  = wide ? mir_full  : mir_half;
  assign brev = wide ? brev_full : brev_half;
endmodule

// File: rtl/bcr_unit.sv
module bcr_unit
  import bcr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic              wide,
  input  logic [DATA_W-1:0] operand,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CNT_W  = IDX_W + 1;

  logic [DATA_W-1:0] width_mask, x_m, sign_fold, enc_in;
  logic              top_bit, none_set;
  logic [IDX_W-1:0]  msb_idx;
  logic [CNT_W-1:0]  width_val, lz_cnt, ls_cnt;
  logic [DATA_W-1:0] mir, brev, hswap, wrev;
  logic [DATA_W-1:0] res_calc, res_d, res_q;
  logic              vld_d, vld_q;
  bcr_op_e           op;

  assign op         = bcr_op_e'(op_sel);
  assign width_mask = wide ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  assign x_m        = operand & width_mask;
  assign top_bit    = wide ? operand[DATA_W-1] : operand[HALF_W-1];
  assign sign_fold  = top_bit ? (x_m ^ width_mask) : x_m;
  assign enc_in     = (op == OP_LSC) ? sign_fold : x_m;
  assign width_val  = wide ? CNT_W'(DATA_W) : CNT_W'(HALF_W);

  bcr_msb_find #(.W(DATA_W), .IDX_W(IDX_W)) i_find (
    .vec      (enc_in),
    .idx      (msb_idx),
    .none_set (none_set)
  );

  always_comb begin
    lz_cnt = none_set ? width_val
                      : width_val - CNT_W'(1) - CNT_W'(msb_idx);
    ls_cnt = none_set ? width_val - CNT_W'(1)
                      : width_val - CNT_W'(2) - CNT_W'(msb_idx);
  end

  bcr_swizzle #(.DATA_W(DATA_W)) i_swz (
    .x_m   (x_m),
    .wide  (wide),
    .mir   (mir),
    .brev  (brev),
    .hswap (hswap),
    .wrev  (wrev)
  );

  always_comb begin
    unique case (op)
      OP_LZC:   res_calc = DATA_W'(lz_cnt);
      OP_LSC:   res_calc = DATA_W'(ls_cnt);
      OP_BMIR:  res_calc = mir;
      OP_BREV:  res_calc = brev;
      OP_HSWAP: res_calc = hswap;
      OP_WREV:  res_calc = wrev;
      default:  res_calc = '0;
    endcase
  end

  // next state
  always_comb begin
    vld_d = in_valid;
    res_d = in_valid ? res_calc : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
endmodule

// File: rtl/bcr_unit_chk.sv
module bcr_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op_sel,
  input logic              wide,
  input logic [DATA_W-1:0] operand,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result))); // R3
  AST_LZC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd0) |=> (result <= DATA_W'(DATA_W))); // R4
  AST_LZC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd0 && wide && operand == '0)
      |=> (result == DATA_W'(DATA_W))); // R4
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[DATA_W-1:HALF_W] == '0)); // R10
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel[2:1] == 2'b11) |=> (result == '0)); // R11
endmodule

bind bcr_unit bcr_unit_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_bcr_unit.sv
module test_bcr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic        wide;
  logic [63:0] operand;
  logic        out_valid;
  logic [63:0] result;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  bcr_unit i_bcr_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .wide(wide), .operand(operand), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] ref_model(input logic [2:0] op,
                                            input logic w, input logic [63:0] x);
    int          wb = w ? 64 : 32;
    logic [63:0] xm = w ? x : {32'b0, x[31:0]};
    logic [63:0] r  = '0;
    int          c;
    case (op)
      3'd0: begin
        c = 0;
        for (int i = wb - 1; i >= 0; i--) begin
          if (xm[i]) break;
          c++;
        end
        r = 64'(c);
      end
      3'd1: begin
        c = 0;
        for (int i = wb - 2; i >= 0; i--) begin
          if (xm[i] != xm[wb-1]) break;
          c++;
        end
        r = 64'(c);
      end
      3'd2: for (int i = 0; i < wb; i++) r[i] = xm[wb-1-i];
      3'd3: for (int b = 0; b < wb / 8; b++) r[8*b +: 8] = xm[8*(wb/8-1-b) +: 8];
      3'd4: for (int l = 0; l < wb / 16; l++) begin
        r[16*l +: 8]   = xm[16*l+8 +: 8];
        r[16*l+8 +: 8] = xm[16*l +: 8];
      end
      3'd5: for (int l = 0; l < wb / 32; l++)
        for (int b = 0; b < 4; b++) r[32*l+8*b +: 8] = xm[32*l+8*(3-b) +: 8];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [2:0] op,
                       input logic w, input logic [63:0] x);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; wide = w; operand = x;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R2 valid"}, 64'(out_valid), 64'd1);
    check(req, result, ref_model(op, w, x));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] x, held;
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; wide = 1'b1; operand = '0;
    repeat (3) @(negedge clk);
    check("R1 valid", 64'(out_valid), 64'd0);
    check("R1 result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after", result, 64'd0);

    // R4 leading zeros
    apply("R4 zero wide", 3'd0, 1'b1, 64'd0);
    apply("R4 zero narrow", 3'd0, 1'b0, 64'd0);
    apply("R4 top bit", 3'd0, 1'b1, 64'h8000_0000_0000_0000);
    apply("R4 lsb", 3'd0, 1'b1, 64'd1);
    apply("R4 narrow lsb", 3'd0, 1'b0, 64'd1);
    // R5 leading sign bits
    apply("R5 zero", 3'd1, 1'b1, 64'd0);
    apply("R5 ones", 3'd1, 1'b1, '1);
    apply("R5 ones narrow", 3'd1, 1'b0, 64'h0000_0000_FFFF_FFFF);
    apply("R5 alt", 3'd1, 1'b1, 64'h4000_0000_0000_0000);
    apply("R5 neg", 3'd1, 1'b1, 64'hC000_0000_0000_0000);
    apply("R5 narrow neg", 3'd1, 1'b0, 64'h1234_5678_F000_0000);
    // R6..R9 with distinct bytes
    apply("R6 mirror", 3'd2, 1'b1, 64'h0123_4567_89AB_CDEF);
    apply("R6 mirror narrow", 3'd2, 1'b0, 64'h0123_4567_89AB_CDEF);
    apply("R7 brev", 3'd3, 1'b1, 64'h0102_0304_0506_0708);
    apply("R7 brev narrow", 3'd3, 1'b0, 64'h0102_0304_0506_0708);
    apply("R8 hswap", 3'd4, 1'b1, 64'h0102_0304_0506_0708);
    apply("R8 hswap narrow", 3'd4, 1'b0, 64'h0102_0304_0506_0708);
    apply("R9 wrev", 3'd5, 1'b1, 64'h0102_0304_0506_0708);
    apply("R9 wrev narrow", 3'd5, 1'b0, 64'h0102_0304_0506_0708);
    // R10 upper half ignored in narrow mode
    apply("R10 clz upper", 3'd0, 1'b0, 64'hFFFF_FFFF_0000_0000);
    apply("R10 hswap upper", 3'd4, 1'b0, 64'hFFFF_FFFF_0000_1234);
    // R11 reserved codes
    apply("R11 op6", 3'd6, 1'b1, 64'hDEAD_BEEF_0000_0001);
    apply("R11 op7", 3'd7, 1'b0, 64'hDEAD_BEEF_0000_0001);

    // R3 hold while idle
    apply("R3 setup", 3'd2, 1'b1, 64'h0000_0000_0000_00F0);
    held = result;
    @(negedge clk);
    op_sel = 3'd3; operand = '1; wide = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R3 held", result, held);
    check("R3 valid low", 64'(out_valid), 64'd0);

    for (int k = 0; k < 600; k++) begin
      x = {$urandom, $urandom} >> ($urandom % 65);
      if ($urandom % 2) x = ~x;
      apply("R4-9 random", 3'($urandom % 8), 1'($urandom % 2), x);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule